// File: doc/BRIEF.md
# Serial-Command Watchdog Supervisor

This block watches a host processor through the commands the host sends over a 16-bit serial link. A shifter outside the block decodes each frame and presents it as a one-cycle strobe with the 16-bit code. The block keeps a status flag that says the host is alive. It combines that flag with the power-good (undervoltage) reset to drive a secondary reset line, which holds the host's peripherals in reset until the host proves it is running.

The host keeps the flag set by sending the trigger code. A trigger is accepted only if some other command has arrived since the previous trigger. The one exception is the first trigger after a power-good reset, which needs no such command. A trigger that breaks this rule clears the flag. The flag also clears when no accepted trigger arrives within a timeout window. The window length is a base cycle count shifted left by a 3-bit prescaler value, and the host writes that value with a dedicated configuration command. A power-good reset returns the prescaler and the sequence state to their defaults.

Top module: `svc_watchdog`

## Requirements
- R1: While `uv_rst_n` is low at a clock edge, `wd_ok` is 0 after that edge. After reset, `wd_ok` stays 0 until a trigger is accepted.
- R2: `rst2_n` equals `uv_rst_n` AND `wd_ok` at all times, with no clock delay from `uv_rst_n`.
- R3: The trigger code is 16'h6A55. An accepted trigger sets `wd_ok` to 1 at the clock edge that samples its strobe, and it restarts the timeout window.
- R4: The first trigger after a power-good reset is accepted even when no other command came before it.
- R5: A trigger with no other command since the previous trigger is rejected. It clears `wd_ok` at the edge that samples it and does not restart the window.
- R6: Any strobed code other than 16'h6A55 counts as an intervening command, and this includes configuration commands.
- R7: With prescaler value p, the limit is L = BASE_CYC << p. If no trigger is accepted, `wd_ok` clears at the (L+1)-th edge after the accepting edge. A trigger strobed while the count equals L is still accepted.
- R8: A configuration command has bits [15:8] = 8'hC3 and bits [7:3] = 0, and it loads p from bits [2:0]. The new p takes effect from the next cycle. A code with bits [15:8] = 8'hC3 but any of bits [7:3] set is an ordinary command and leaves p unchanged. After reset, p = DEF_PS (1).
- R9: A power-good reset restores p to its default and restores the first-trigger exemption.
- R10: After a timeout, an accepted trigger (with another command before it) sets `wd_ok` to 1 again.
- R11: When `cmd_stb` is low, `cmd_code` is ignored: it neither triggers nor configures nor counts as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| uv_rst_n | input | 1 | Power-good reset, active low, sampled synchronously |
| cmd_stb | input | 1 | One-cycle strobe marking a decoded serial command |
| cmd_code | input | 16 | Code of the strobed command |
| rst2_n | output | 1 | Secondary reset, active low |
| wd_ok | output | 1 | Watchdog status: 1 while the host is considered alive |

## Verification
`wd_ok` is registered, so every command strobe shows its effect after the first rising edge that samples it. The bench therefore drives on the falling edge and compares a quarter period after the next rising edge. `rst2_n` is combinational from `uv_rst_n`, so one check drops the reset between edges and samples `rst2_n` before any edge. Timeout checks count edges from the accepting edge: the flag must still be high after L edges and low after L+1. The table walk covers the sequence rules one cycle per row, and directed cases cover the window boundary, prescaler values 0 and 2, a look-alike configuration code, and recovery after timeout.

// File: rtl/svc_wd_pkg.sv
// svc_wd_pkg: command codes and the command class shared by the watchdog blocks.
// Assumes 16-bit command codes; the configuration header sits in bits [15:8].
package svc_wd_pkg;

    localparam logic [15:0] TRIG_CODE = 16'h6A55;
    localparam logic [7:0]  CFG_HDR   = 8'hC3;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_TRIG  = 2'd1,
        CMD_CFG   = 2'd2,
        CMD_OTHER = 2'd3
    } cmd_kind_t;

endpackage

// File: rtl/svc_wd_cmd_class.sv
// svc_wd_cmd_class: sorts a strobed command into trigger, configuration or other.
// Assumes PS_W < 8 so the configuration field and its zero guard both fit in the low byte.
module svc_wd_cmd_class
    import svc_wd_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic            cmd_stb,
    input  logic [15:0]     cmd_code,
    output cmd_kind_t       kind,
    output logic [PS_W-1:0] cfg_val
);

    logic is_cfg_code;

    // Configuration form: fixed header and zero guard bits above the field
    always_comb begin
        is_cfg_code = (cmd_code[15:8] == CFG_HDR) && (cmd_code[7:PS_W] == '0);
    end

    // Classification; no strobe means no command at all
    always_comb begin
        if (!cmd_stb)                    kind = CMD_NONE;
        else if (cmd_code == TRIG_CODE)  kind = CMD_TRIG;
        else if (is_cfg_code)            kind = CMD_CFG;
        else                             kind = CMD_OTHER;
    end

    // Field carried by a configuration command
    always_comb begin
        cfg_val = cmd_code[PS_W-1:0];
    end

endmodule

// File: rtl/svc_wd_seq.sv
// svc_wd_seq: enforces the rule that a different command must come between two triggers.
// Assumes a synchronous active-low reset; the first trigger after reset is exempt from the rule.
module svc_wd_seq
    import svc_wd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cmd_kind_t kind,
    output logic      trig_accept,
    output logic      trig_reject
);

    logic first_q;   // no trigger seen since reset
    logic diff_q;    // another command seen since the last trigger
    logic is_trig;

    // Trigger decision from the current sequence state
    always_comb begin
        is_trig     = (kind == CMD_TRIG);
        trig_accept = is_trig && (first_q || diff_q);
        trig_reject = is_trig && !(first_q || diff_q);
    end

    // Sequence state update on every strobed command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            diff_q  <= 1'b0;
        end else if (is_trig) begin
            first_q <= 1'b0;
            diff_q  <= 1'b0;
        end else if (kind == CMD_CFG || kind == CMD_OTHER) begin
            diff_q  <= 1'b1;
        end
    end

endmodule

// File: rtl/svc_wd_window.sv
// svc_wd_window: prescaler register and timeout counter for the trigger window.
// Assumes the limit BASE_CYC << p fits the derived counter width; counts saturate at the limit.
module svc_wd_window #(
    parameter int BASE_CYC = 16,
    parameter int PS_W     = 3,
    parameter int DEF_PS   = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [PS_W-1:0] cfg_val,
    input  logic            restart,
    output logic [PS_W-1:0] ps_q,
    output logic            expire
);

    localparam int NUM_PS  = 1 << PS_W;
    localparam int MAX_LIM = BASE_CYC << (NUM_PS - 1);
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    logic [CNT_W-1:0] lim_tab [NUM_PS];
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_q;

    // One limit per prescaler value
    for (genvar g = 0; g < NUM_PS; g++) begin : g_lim
        assign lim_tab[g] = CNT_W'(BASE_CYC) << g;
    end

    // Current limit selected by the prescaler
    always_comb begin
        limit  = lim_tab[ps_q];
        expire = (cnt_q >= limit);
    end

    // Prescaler register, written by the configuration command
    always_ff @(posedge clk) begin
        if (!rst_n)      ps_q <= PS_W'(DEF_PS);
        else if (cfg_we) ps_q <= cfg_val;
    end

    // Cycles since the last accepted trigger, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (restart)       cnt_q <= '0;
        else if (cnt_q < limit) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/svc_watchdog.sv
// svc_watchdog: serial-command watchdog that drives a secondary reset from the host's trigger stream.
// Assumes cmd_stb is a one-cycle pulse per decoded command and uv_rst_n is synchronous to clk.
module svc_watchdog
    import svc_wd_pkg::*;
#(
    parameter int BASE_CYC = 16,
    parameter int PS_W     = 3,
    parameter int DEF_PS   = 1
) (
    input  logic        clk,
    input  logic        uv_rst_n,
    input  logic        cmd_stb,
    input  logic [15:0] cmd_code,
    output logic        rst2_n,
    output logic        wd_ok
);

    cmd_kind_t       kind;
    logic [PS_W-1:0] cfg_val;
    logic [PS_W-1:0] ps_cur;
    logic            trig_accept;
    logic            trig_reject;
    logic            win_expire;
    logic            ok_q;

    svc_wd_cmd_class #(.PS_W(PS_W)) u_class (
        .cmd_stb  (cmd_stb),
        .cmd_code (cmd_code),
        .kind     (kind),
        .cfg_val  (cfg_val)
    );

    svc_wd_seq u_seq (
        .clk         (clk),
        .rst_n       (uv_rst_n),
        .kind        (kind),
        .trig_accept (trig_accept),
        .trig_reject (trig_reject)
    );

    svc_wd_window #(
        .BASE_CYC (BASE_CYC),
        .PS_W     (PS_W),
        .DEF_PS   (DEF_PS)
    ) u_win (
        .clk     (clk),
        .rst_n   (uv_rst_n),
        .cfg_we  (kind == CMD_CFG),
        .cfg_val (cfg_val),
        .restart (trig_accept),
        .ps_q    (ps_cur),
        .expire  (win_expire)
    );

    // Alive flag: set by an accepted trigger, cleared by a rejected one or a timeout
    always_ff @(posedge clk) begin
        if (!uv_rst_n)                     ok_q <= 1'b0;
        else if (trig_accept)              ok_q <= 1'b1;
        else if (trig_reject || win_expire) ok_q <= 1'b0;
    end

    // Outputs: status flag and the combined secondary reset
    always_comb begin
        wd_ok  = ok_q;
        rst2_n = uv_rst_n & ok_q;
    end

endmodule

// File: rtl/svc_watchdog_chk.sv
// svc_watchdog_chk: temporal checks on the watchdog, bound into every svc_watchdog instance.
// Assumes it observes the top's internal accept, expire and prescaler nets through the bind.
module svc_watchdog_chk #(
    parameter int PS_W   = 3,
    parameter int DEF_PS = 1
) (
    input logic            clk,
    input logic            uv_rst_n,
    input logic            cmd_stb,
    input logic [15:0]     cmd_code,
    input logic            rst2_n,
    input logic            wd_ok,
    input logic            trig_accept,
    input logic            win_expire,
    input logic [PS_W-1:0] ps_cur
);

    // R1
    reset_clears_ok_chk: assert property (@(posedge clk) !uv_rst_n |=> !wd_ok);

    // R2
    rst2_low_in_reset_chk: assert property (@(posedge clk) !uv_rst_n |-> !rst2_n);

    // R2
    rst2_needs_ok_chk: assert property (@(posedge clk) !wd_ok |-> !rst2_n);

    // R3
    accept_sets_ok_chk: assert property (@(posedge clk) disable iff (!uv_rst_n)
        trig_accept |=> wd_ok);

    // R5
    reject_clears_ok_chk: assert property (@(posedge clk) disable iff (!uv_rst_n)
        (cmd_stb && cmd_code == 16'h6A55 && !trig_accept) |=> !wd_ok);

    // R7
    expire_clears_ok_chk: assert property (@(posedge clk) disable iff (!uv_rst_n)
        (win_expire && !trig_accept) |=> !wd_ok);

    // R8
    default_ps_chk: assert property (@(posedge clk) !uv_rst_n |=> (ps_cur == PS_W'(DEF_PS)));

    // R11
    ps_hold_chk: assert property (@(posedge clk) disable iff (!uv_rst_n)
        !cmd_stb |=> $stable(ps_cur));

endmodule

bind svc_watchdog svc_watchdog_chk #(.PS_W(PS_W), .DEF_PS(DEF_PS)) u_chk (
    .clk         (clk),
    .uv_rst_n    (uv_rst_n),
    .cmd_stb     (cmd_stb),
    .cmd_code    (cmd_code),
    .rst2_n      (rst2_n),
    .wd_ok       (wd_ok),
    .trig_accept (trig_accept),
    .win_expire  (win_expire),
    .ps_cur      (ps_cur)
);

// File: tb/svc_watchdog_bench.sv
// svc_watchdog_bench: table walk of sequence rules, then directed window, prescaler and reset cases.
module svc_watchdog_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BASE_CYC   = 16;
    localparam int NROWS      = 14;
    localparam logic [15:0] TRIG = 16'h6A55;

    logic        clk = 1'b0;
    logic        uv_rst_n = 1'b0;
    logic        cmd_stb = 1'b0;
    logic [15:0] cmd_code = 16'h0000;
    logic        rst2_n;
    logic        wd_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    svc_watchdog u_svc_watchdog (
        .clk      (clk),
        .uv_rst_n (uv_rst_n),
        .cmd_stb  (cmd_stb),
        .cmd_code (cmd_code),
        .rst2_n   (rst2_n),
        .wd_ok    (wd_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Row fields: {uv_rst_n, cmd_stb, cmd_code, expected wd_ok after the edge}
    localparam logic [18:0] VEC [NROWS] = '{
        {1'b0, 1'b0, 16'h0000, 1'b0},  // R1 reset
        {1'b1, 1'b0, 16'h0000, 1'b0},  // R1 idle after reset stays low
        {1'b1, 1'b1, TRIG,     1'b1},  // R4 R3 first trigger exempt
        {1'b1, 1'b1, TRIG,     1'b0},  // R5 back-to-back trigger rejected
        {1'b1, 1'b1, 16'h1234, 1'b0},  // R6 other command
        {1'b1, 1'b1, TRIG,     1'b1},  // R3 accepted after other command
        {1'b1, 1'b1, 16'hC305, 1'b1},  // R8 config p=5
        {1'b1, 1'b1, TRIG,     1'b1},  // R6 config counts as different
        {1'b1, 1'b0, TRIG,     1'b1},  // R11 unstrobed code ignored
        {1'b1, 1'b1, TRIG,     1'b0},  // R11 R5 no command between
        {1'b1, 1'b1, 16'hABCD, 1'b0},  // R6
        {1'b1, 1'b1, TRIG,     1'b1},  // R3
        {1'b0, 1'b0, 16'h0000, 1'b0},  // R9 reset mid-run
        {1'b1, 1'b1, TRIG,     1'b1}   // R9 exemption restored
    };

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, wait for the rising edge, settle
    task automatic cyc(input logic uv, input logic stb, input logic [15:0] code);
        @(negedge clk);
        uv_rst_n = uv;
        cmd_stb  = stb;
        cmd_code = code;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // Table walk: sequence rules, one cycle per row
        for (int i = 0; i < NROWS; i++) begin
            cyc(VEC[i][18], VEC[i][17], VEC[i][16:1]);
            chk(wd_ok, VEC[i][0], $sformatf("R1/R3/R4/R5/R6/R9/R11 row %0d wd_ok", i));
            chk(rst2_n, VEC[i][18] & VEC[i][0], $sformatf("R2 row %0d rst2_n", i));
        end

        // R7 timeout at default prescaler p=1, L=32
        cyc(1'b0, 1'b0, 16'h0000);
        cyc(1'b1, 1'b1, TRIG);
        idle(BASE_CYC << 1);
        chk(wd_ok, 1'b1, "R7 still ok after L edges");
        idle(1);
        chk(wd_ok, 1'b0, "R7 cleared after L+1 edges");
        chk(rst2_n, 1'b0, "R2 rst2_n low after timeout");
        cyc(1'b1, 1'b1, TRIG);
        chk(wd_ok, 1'b0, "R5 trigger after timeout without other command");
        cyc(1'b1, 1'b1, 16'h0001);
        cyc(1'b1, 1'b1, TRIG);
        chk(wd_ok, 1'b1, "R10 recovery after timeout");

        // R7 trigger at count == L is accepted and restarts the window
        cyc(1'b0, 1'b0, 16'h0000);
        cyc(1'b1, 1'b1, TRIG);
        cyc(1'b1, 1'b1, 16'h0042);
        idle((BASE_CYC << 1) - 1);
        chk(wd_ok, 1'b1, "R7 ok at count L");
        cyc(1'b1, 1'b1, TRIG);
        chk(wd_ok, 1'b1, "R7 boundary trigger accepted");
        idle(BASE_CYC << 1);
        chk(wd_ok, 1'b1, "R3 window restarted");
        idle(1);
        chk(wd_ok, 1'b0, "R7 restarted window expires");

        // R8 prescaler p=0, L=16
        cyc(1'b0, 1'b0, 16'h0000);
        cyc(1'b1, 1'b1, TRIG);
        cyc(1'b1, 1'b1, 16'hC300);
        idle(BASE_CYC - 1);
        chk(wd_ok, 1'b1, "R8 p=0 ok at L");
        idle(1);
        chk(wd_ok, 1'b0, "R8 p=0 expired at L+1");

        // R8 prescaler p=2, L=64
        cyc(1'b1, 1'b1, 16'hC302);
        cyc(1'b1, 1'b1, TRIG);
        chk(wd_ok, 1'b1, "R10 R6 config before trigger");
        idle(BASE_CYC << 2);
        chk(wd_ok, 1'b1, "R8 p=2 ok at L");
        idle(1);
        chk(wd_ok, 1'b0, "R8 p=2 expired at L+1");

        // R8 R9 look-alike code leaves default p=1 after reset
        cyc(1'b0, 1'b0, 16'h0000);
        cyc(1'b1, 1'b1, TRIG);
        cyc(1'b1, 1'b1, 16'hC30A);
        idle((BASE_CYC << 1) - 1);
        chk(wd_ok, 1'b1, "R9 default p ok at L");
        idle(1);
        chk(wd_ok, 1'b0, "R8 look-alike code did not configure");

        // R2 combinational path: drop reset between edges
        cyc(1'b1, 1'b1, 16'h0003);
        cyc(1'b1, 1'b1, TRIG);
        chk(wd_ok, 1'b1, "R3 ok before reset drop");
        @(negedge clk);
        uv_rst_n = 1'b0;
        cmd_stb  = 1'b0;
        #1;
        chk(rst2_n, 1'b0, "R2 rst2_n follows uv_rst_n without a clock");
        chk(wd_ok, 1'b1, "R1 flag holds until the edge");
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(wd_ok, 1'b0, "R1 flag cleared at reset edge");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule